// File: doc/BRIEF.md
# Synchronous DRAM Burst Data Path with Clock Suspension

This block models the data side of a synchronous DRAM column access. A read or write strobe with a column address starts a burst. By default the burst is four beats long and wraps inside its aligned group of columns. In full-page mode it runs through the whole page until another command arrives.

Read data leaves through a pipeline whose depth is set by a static CAS-latency select (two or three clocks). The read bus is a data word plus an enable flag; a low enable stands for high impedance.

Two controls bend the timing:
- A clock-enable input freezes the internal burst clock one edge after it is seen low, and releases it one edge after it is seen high again.
- A byte-lane-style mask input blocks write beats in the same cycle, but blanks read beats two clocks later. In both directions the burst keeps moving past the masked beat.

A small word array, cleared by reset, holds the written data.

Top module: `sdram_burst_datapath`

## Requirements
- R1: After reset the enable flag `rdata_oe` is 0 and every array word reads back as 0.
- R2: A read accepted at internal edge t drives its first beat from edge t+1 when `cas_lat3`=0 (latency 2), or from edge t+2 when `cas_lat3`=1 (latency 3). Each later beat follows one internal edge after the previous one.
- R3: With `full_page`=0 a burst has four beats. The column for beat k is formed by keeping the start column's upper bits and replacing its lower 2 bits with (start+k) mod 4. After the fourth beat no further beat is produced.
- R4: With `full_page`=1 the column for beat k is (start+k) mod 2**COL_W. The burst never ends by itself; only a new command stops it.
- R5: `cke` sampled low at edge n suspends the internal clock from edge n+1. `cke` sampled high resumes it from the following edge. Commands present at a suspended edge are ignored.
- R6: At a suspended edge during a write, the data bus is not stored and the beat counter does not advance.
- R7: At a suspended edge during a read, the current output word is held instead of advancing.
- R8: During a write, `dqm` high at an edge prevents that beat from being stored, and the burst still advances to the next column.
- R9: `dqm` sampled high at edge e forces `rdata_oe` low from edge e+1 to edge e+2. This holds even when the clock is suspended, and the read burst still advances past the masked beat.
- R10: A command accepted during a burst ends that burst, and the new burst's first beat uses that same edge. When `cmd_rd` and `cmd_wr` are both high, the read wins.
- R11: `rdata_oe` is 0 whenever no read beat has reached the output: before the latency expires, after the last beat, and during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | Static latency select: 0 for two clocks, 1 for three |
| full_page | input | 1 | Static mode: 1 makes bursts run through the page |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| col_addr | input | COL_W | Start column of the commanded burst |
| cke | input | 1 | Clock enable; low suspends the internal clock one edge later |
| dqm | input | 1 | Data mask for write beats (same edge) and read beats (two clocks later) |
| wdata | input | DW | Write data beat |
| rdata | output | DW | Read data, zero while not enabled |
| rdata_oe | output | 1 | Read drive enable; 0 means high impedance |

## Verification
Suspension and masking can land on the same read beat. When that happens, the held word must also be blanked two clocks after the mask was raised, and the two effects must not interfere.

The bench provokes this by holding `cke` low across a read while pulsing `dqm`, in both latency settings and in full-page mode. Random stimulus then mixes both inputs at once. A cycle model in the bench, built from the requirements, predicts the enable and data on every cycle, and each cycle is judged against it.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef enum logic [1:0] {
      SDP_IDLE  = 2'd0,
      SDP_READ  = 2'd1,
      SDP_WRITE = 2'd2
   } sdp_mode_e;
endpackage

// File: rtl/sdp_col_gen.sv
// Column of the current beat: wraps in the burst group or across the page.
module sdp_col_gen #(
   parameter int COL_W = 4,
   parameter int BL_W  = 2
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] idx,
   input  logic             full_page,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] lin;
   logic [COL_W-1:0] grp;

   assign lin = base + idx;

   generate
      if (BL_W == COL_W) begin : g_whole
         assign grp = lin;
      end else begin : g_part
         assign grp = {base[COL_W-1:BL_W], lin[BL_W-1:0]};
      end
   endgenerate

   assign col = full_page ? lin : grp;
endmodule

// File: rtl/sdp_store.sv
// Word array with one write port and one combinational read port.
module sdp_store #(
   parameter int DW    = 16,
   parameter int COL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [COL_W-1:0] col,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int DEPTH = 1 << COL_W;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[col] <= wdata;
      end
   end

   assign rdata = mem[col];
endmodule

// File: rtl/sdp_rd_pipe.sv
// Latency pipe clocked by the internal enable; mask delay on the plain clock.
module sdp_rd_pipe #(
   parameter int DW       = 16,
   parameter int STAGES   = 3,
   parameter int MASK_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          sel_late,
   input  logic          dqm,
   output logic          oe,
   output logic [DW-1:0] data,
   output logic [DW-1:0] held_data
);
   logic          v [STAGES];
   logic [DW-1:0] d [STAGES];
   logic          m [MASK_LAT];
   logic          v_out;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdp_rd_pipe: STAGES must be at least 2");
      end
      if (MASK_LAT < 1) begin : g_bad_mask
         $error("sdp_rd_pipe: MASK_LAT must be at least 1");
      end

      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  v[0] <= 1'b0;
                  d[0] <= '0;
               end else if (run) begin
                  v[0] <= push;
                  d[0] <= push_data;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  v[i] <= 1'b0;
                  d[i] <= '0;
               end else if (run) begin
                  v[i] <= v[i-1];
                  d[i] <= d[i-1];
               end
            end
         end
      end

      for (genvar j = 0; j < MASK_LAT; j++) begin : g_mask
         if (j == 0) begin : g_m0
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) m[0] <= 1'b0;
               else        m[0] <= dqm;
            end
         end else begin : g_mn
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) m[j] <= 1'b0;
               else        m[j] <= m[j-1];
            end
         end
      end
   endgenerate

   assign v_out     = sel_late ? v[STAGES-1] : v[STAGES-2];
   assign held_data = sel_late ? d[STAGES-1] : d[STAGES-2];
   assign oe        = v_out && !m[MASK_LAT-1];
   assign data      = oe ? held_data : '0;
endmodule

// File: rtl/sdram_burst_datapath.sv
module sdram_burst_datapath
   import sdp_pkg::*;
#(
   parameter int DW        = 16,
   parameter int COL_W     = 4,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cas_lat3,
   input  logic             full_page,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic [COL_W-1:0] col_addr,
   input  logic             cke,
   input  logic             dqm,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe
);
   localparam int BL_W            = $clog2(BURST_LEN);
   localparam logic [COL_W-1:0] LAST_IDX = COL_W'(BURST_LEN - 1);
   localparam int PIPE_STAGES     = 3;
   localparam int READ_MASK_LAT   = 2;

   generate
      if (BURST_LEN < 2 || (1 << BL_W) != BURST_LEN) begin : g_bad_bl
         $error("sdram_burst_datapath: BURST_LEN must be a power of two >= 2");
      end
      if (BL_W > COL_W) begin : g_bad_col
         $error("sdram_burst_datapath: burst longer than the page");
      end
      if (DW < 1) begin : g_bad_dw
         $error("sdram_burst_datapath: DW must be positive");
      end
   endgenerate

   // Internal clock enable, one edge behind cke
   logic             run;
   sdp_mode_e        mode;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] cnt;

   logic             take;
   sdp_mode_e        cur_mode;
   logic [COL_W-1:0] cur_base;
   logic [COL_W-1:0] cur_idx;
   logic             beat;
   logic [COL_W-1:0] col;
   logic             we;
   logic             push;
   logic [DW-1:0]    mem_q;
   logic [DW-1:0]    out_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b1;
      else        run <= cke;
   end

   always_comb begin
      take     = run && (cmd_rd || cmd_wr);
      cur_mode = mode;
      cur_base = base;
      cur_idx  = cnt;
      if (take) begin
         cur_mode = cmd_rd ? SDP_READ : SDP_WRITE;
         cur_base = col_addr;
         cur_idx  = '0;
      end
      beat = run && (cur_mode != SDP_IDLE);
      we   = beat && (cur_mode == SDP_WRITE) && !dqm;
      push = beat && (cur_mode == SDP_READ);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= SDP_IDLE;
         base <= '0;
         cnt  <= '0;
      end else if (beat) begin
         base <= cur_base;
         cnt  <= cur_idx + 1'b1;
         mode <= (!full_page && cur_idx == LAST_IDX) ? SDP_IDLE : cur_mode;
      end
   end

   sdp_col_gen #(.COL_W(COL_W), .BL_W(BL_W)) i_col (
      .base      (cur_base),
      .idx       (cur_idx),
      .full_page (full_page),
      .col       (col)
   );

   sdp_store #(.DW(DW), .COL_W(COL_W)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .col   (col),
      .wdata (wdata),
      .rdata (mem_q)
   );

   sdp_rd_pipe #(.DW(DW), .STAGES(PIPE_STAGES), .MASK_LAT(READ_MASK_LAT)) i_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .push      (push),
      .push_data (mem_q),
      .sel_late  (cas_lat3),
      .dqm       (dqm),
      .oe        (rdata_oe),
      .data      (rdata),
      .held_data (out_data)
   );
endmodule

// File: rtl/sdp_chk.sv
module sdp_chk #(
   parameter int DW        = 16,
   parameter int COL_W     = 4,
   parameter int BURST_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             full_page,
   input logic             dqm,
   input logic             rdata_oe,
   input logic             run,
   input logic [1:0]       mode,
   input logic [COL_W-1:0] cnt,
   input logic [DW-1:0]    out_data
);
   logic dq1, dq2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq1 <= 1'b0;
         dq2 <= 1'b0;
      end else begin
         dq1 <= dqm;
         dq2 <= dq1;
      end
   end

   // R9
   read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq2 |-> !rdata_oe);

   // R7
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(out_data));

   // R6
   write_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(cnt) && $stable(mode)));

   // R3
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_page && mode != 2'd0) |-> (cnt <= COL_W'(BURST_LEN - 1)));
endmodule

bind sdram_burst_datapath sdp_chk #(
   .DW(DW), .COL_W(COL_W), .BURST_LEN(BURST_LEN)
) i_sdp_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .full_page (full_page),
   .dqm       (dqm),
   .rdata_oe  (rdata_oe),
   .run       (run),
   .mode      (mode),
   .cnt       (cnt),
   .out_data  (out_data)
);

// File: tb/test_sdram_burst_datapath.sv
module test_sdram_burst_datapath;
   localparam int DW = 16;
   localparam int CW = 4;
   localparam int PAGE = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cas_lat3 = 1'b0;
   logic          full_page = 1'b0;
   logic          cmd_rd = 1'b0, cmd_wr = 1'b0;
   logic [CW-1:0] col_addr = '0;
   logic          cke = 1'b1, dqm = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int checks = 0;
   int fails = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   sdram_burst_datapath #(.DW(DW), .COL_W(CW), .BURST_LEN(4)) i_sdram_burst_datapath (
      .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .full_page(full_page),
      .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .col_addr(col_addr), .cke(cke),
      .dqm(dqm), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

   // Cycle model built from the requirements
   logic [DW-1:0] mm [PAGE];
   logic          pv [3];
   logic [DW-1:0] pd [3];
   logic          m_ckq, mq1, mq2;
   int            m_mode, m_cnt, m_base;

   function automatic int col_of(int b, int k, logic fp);
      if (fp) return (b + k) % PAGE;
      return (b & ~3) | ((b + k) & 3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE; i++) mm[i] = '0;
         for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
         m_ckq = 1'b1; mq1 = 1'b0; mq2 = 1'b0;
         m_mode = 0; m_cnt = 0; m_base = 0;
      end else begin
         logic en, nv;
         logic [DW-1:0] nd;
         int idx, c;
         en = m_ckq; m_ckq = cke;
         mq2 = mq1; mq1 = dqm;
         if (en) begin
            nv = 1'b0; nd = '0; idx = m_cnt;
            if (cmd_rd || cmd_wr) begin
               m_mode = cmd_rd ? 1 : 2; m_base = int'(col_addr); idx = 0;
            end
            if (m_mode != 0) begin
               c = col_of(m_base, idx, full_page);
               if (m_mode == 2 && !dqm) mm[c] = wdata;
               if (m_mode == 1) begin nv = 1'b1; nd = mm[c]; end
               m_cnt = (idx + 1) % PAGE;
               if (!full_page && idx == 3) m_mode = 0;
            end
            pv[2] = pv[1]; pd[2] = pd[1];
            pv[1] = pv[0]; pd[1] = pd[0];
            pv[0] = nv;    pd[0] = nd;
         end
      end
   end

   task automatic compare();
      logic ev, eoe;
      logic [DW-1:0] ed;
      ev  = cas_lat3 ? pv[2] : pv[1];
      ed  = cas_lat3 ? pd[2] : pd[1];
      eoe = ev && !mq2;
      checks++;
      if (rdata_oe !== eoe || (eoe && rdata !== ed) || (!eoe && rdata !== '0)) begin
         fails++;
         $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", phase,
                  rdata_oe, rdata, eoe, eoe ? ed : '0);
      end
   endtask

   task automatic step(input logic rd, input logic wr, input int c,
                       input logic ck, input logic dm, input logic [DW-1:0] wd);
      @(negedge clk);
      compare();
      cmd_rd = rd; cmd_wr = wr; col_addr = CW'(c);
      cke = ck; dqm = dm; wdata = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, '0);
   endtask

   task automatic rand_run(input int n);
      for (int i = 0; i < n; i++) begin
         int r;
         logic rd, wr;
         r = int'($urandom % 100);
         rd = (r < 6); wr = (r >= 6 && r < 12) || (r == 3);
         step(rd, wr, int'($urandom % PAGE), ($urandom % 100) >= 20,
              ($urandom % 100) < 20, DW'($urandom));
      end
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: enable low after reset
      checks++;
      if (rdata_oe !== 1'b0) begin
         fails++;
         $display("FAIL R1: oe=%0b expected 0", rdata_oe);
      end
      phase = "R1"; step(1, 0, 7, 1, 0, '0); idle(6);
      // R3: write burst from column 5 wraps 5,6,7,4; read it back (R2, latency 2)
      phase = "R3";
      step(0, 1, 5, 1, 0, 16'hA000);
      for (int k = 1; k < 4; k++) step(0, 0, 0, 1, 0, 16'hA000 + DW'(k));
      phase = "R2"; step(1, 0, 5, 1, 0, '0); idle(6);
      cas_lat3 = 1'b1; step(1, 0, 6, 1, 0, '0); idle(6);
      // R8: mask the second write beat
      phase = "R8";
      step(0, 1, 8, 1, 0, 16'hB000);
      step(0, 0, 0, 1, 1, 16'hB001);
      step(0, 0, 0, 1, 0, 16'hB002);
      step(0, 0, 0, 1, 0, 16'hB003);
      step(1, 0, 8, 1, 0, '0); idle(6);
      // R6: suspend in a write
      phase = "R6";
      step(0, 1, 12, 1, 0, 16'hC000);
      step(0, 0, 0, 0, 0, 16'hC001);
      step(0, 0, 0, 0, 0, 16'hC0EE);
      step(0, 0, 0, 1, 0, 16'hC0FF);
      step(0, 0, 0, 1, 0, 16'hC002);
      step(0, 0, 0, 1, 0, 16'hC003);
      step(1, 0, 12, 1, 0, '0); idle(6);
      // R7: suspend in a read
      phase = "R7";
      step(1, 0, 4, 1, 0, '0);
      step(0, 0, 0, 1, 0, '0); step(0, 0, 0, 0, 0, '0);
      step(0, 0, 0, 0, 0, '0); step(0, 0, 0, 1, 0, '0); idle(6);
      // R9: read mask alone and with suspension
      phase = "R9";
      cas_lat3 = 1'b0;
      step(1, 0, 12, 1, 0, '0); step(0, 0, 0, 1, 1, '0); idle(6);
      step(1, 0, 8, 1, 0, '0); step(0, 0, 0, 0, 1, '0);
      step(0, 0, 0, 0, 0, '0); step(0, 0, 0, 1, 1, '0); idle(6);
      // R5: command at a suspended edge is ignored
      phase = "R5";
      step(0, 0, 0, 0, 0, '0); step(1, 0, 4, 1, 0, '0); idle(6);
      // R10: interruption and simultaneous strobes
      phase = "R10";
      step(1, 0, 4, 1, 0, '0); step(0, 0, 0, 1, 0, '0);
      step(0, 1, 0, 1, 0, 16'hD000); step(0, 0, 0, 1, 0, 16'hD001);
      step(1, 1, 0, 1, 0, 16'hDEAD); idle(6);
      phase = "R11"; idle(4);
      // Random segments: burst mode first, then full-page mode (R4)
      phase = "R2"; cas_lat3 = 1'b0; rand_run(1500);
      phase = "R9"; cas_lat3 = 1'b1; rand_run(1500);
      phase = "R4"; full_page = 1'b1; cas_lat3 = 1'b0;
      step(1, 0, 14, 1, 0, '0); idle(24);
      rand_run(1500);
      cas_lat3 = 1'b1; rand_run(1500);
   endtask

   initial begin
      void'($urandom(32'd2718));
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule